// File: doc/BRIEF.md
# Reserved-Line Request Parking Lists

This block holds requests that reach a directory while the line they target is locked during a memory fill. Each locked line has its own ordered list. All lists draw entries from one shared pool of slots, and a free map tracks which slots are unused. Each list has a head pointer, a tail pointer and an occupancy flag. A request for a line that is unlocked and has nothing parked goes straight out on the bypass port in the same cycle. Any other request is linked onto the tail of its line's list and is not processed.

When the fill for a line completes, the line is unlocked. If its list holds anything, the line index enters a small queue of servable lines, and it enters that queue at most once. The consumer drains the line at the front of that queue through a head view. A request that it cannot complete yet can be linked back in front of the list, so the original order is kept. A slot popped from a list returns to the free map on the same edge.

Top module: `reqlist_mgr`

## Requirements
- R1: After reset every pool slot is free, no line is locked, every list is empty and the servable-line queue is empty: `net_ready`=1, `act_valid`=0, `hd_valid`=0, `byp_valid`=0.
- R2: An accepted arrival goes out on `byp_valid`/`byp_line`/`byp_data` in the same cycle when all of these hold: its line is unlocked, its list is empty, and no re-insertion targets that line in that cycle. No slot is used for it.
- R3: An accepted arrival for a locked line, or for a line whose list is not empty, is appended at the tail of that line's list and does not appear on the bypass port.
- R4: `fill_valid` unlocks `fill_line`. The line index is appended to the servable-line queue only when its list is then not empty and the line is not already in the queue. A fill on an empty list queues nothing.
- R5: While `act_valid`=1, `hd_valid` and `hd_data` show the head of the list of `act_line`. `hd_pop` removes that head, and the freed slot can be allocated from the next cycle.
- R6: `rq_valid` (effective only while `act_valid`=1) links `rq_data` in front of the list of `act_line`, so it is served before every older entry of that line.
- R7: `net_ready` is 0 when no slot is free. It is also 0 when exactly one slot is free and a re-insertion takes it in the same cycle. An arrival offered while `net_ready`=0 is neither parked nor bypassed.
- R8: `act_pop` removes the front of the servable-line queue, unless that line's list is still not empty and the line is unlocked after this cycle's updates. In that case the pop is ignored and the line stays at the front.
- R9: When `rsv_valid` and `fill_valid` name the same line in one cycle, the lock wins: the line stays locked and is not queued.
- R10: Lines are presented on `act_line` in the order their fills made them servable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsv_valid | input | 1 | Lock a line (fill started) |
| rsv_line | input | LINES_W | Line to lock |
| fill_valid | input | 1 | Fill for a line finished |
| fill_line | input | LINES_W | Line whose fill finished |
| net_valid | input | 1 | Arrival offered |
| net_ready | output | 1 | Arrival can be taken this cycle |
| net_line | input | LINES_W | Line targeted by the arrival |
| net_data | input | DATA_W | Request payload |
| byp_valid | output | 1 | Arrival passes straight through |
| byp_line | output | LINES_W | Line of the passed-through arrival |
| byp_data | output | DATA_W | Payload of the passed-through arrival |
| act_valid | output | 1 | Servable-line queue not empty |
| act_line | output | LINES_W | Line at the front of the servable-line queue |
| act_pop | input | 1 | Retire the front line |
| hd_valid | output | 1 | Front line has a parked request |
| hd_data | output | DATA_W | Head request of the front line |
| hd_pop | input | 1 | Remove the head request |
| rq_valid | input | 1 | Re-insert a request at the head of the front line |
| rq_data | input | DATA_W | Payload to re-insert |

## Verification
The bench builds the block with 8 lines, a 16-slot pool and 16-bit payloads. With only 16 slots, the pool can be filled completely within a few dozen cycles. That makes both not-ready cases reachable: the pool fully empty, and one slot left that a re-insertion takes. Eight lines are enough to mix locked, servable and re-locked lines in the servable queue and to check that a line is queued only once. They also allow an arrival, a pop and a re-insertion on the same line in one cycle.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
  // index of the lowest set bit among the first n bits, 0 when none is set
  function automatic int lowest_set(input logic [63:0] m, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--)
      if (m[i]) r = i;
    return r;
  endfunction

  // number of set bits among the first n bits
  function automatic int bits_set(input logic [63:0] m, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++)
      c += int'(m[i]);
    return c;
  endfunction
endpackage

// File: rtl/rlm_freemap.sv
module rlm_freemap #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take0,
  input  logic                       take1,
  input  logic                       give,
  input  logic [$clog2(DEPTH)-1:0]   give_idx,
  output logic [$clog2(DEPTH)-1:0]   slot0,
  output logic [$clog2(DEPTH)-1:0]   slot1,
  output logic [$clog2(DEPTH+1)-1:0] free_cnt
);
  import rlm_pkg::*;
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] free_q, rest, free_n;

  always_comb begin
    slot0 = IW'(lowest_set(64'(free_q), DEPTH));
    rest = free_q;
    rest[slot0] = 1'b0;
    slot1 = IW'(lowest_set(64'(rest), DEPTH));
    free_cnt = CW'(bits_set(64'(free_q), DEPTH));
  end

  always_comb begin
    free_n = free_q;
    if (take0) free_n[slot0] = 1'b0;
    if (take1) free_n[slot1] = 1'b0;
    if (give)  free_n[give_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) free_q <= '1;
    else        free_q <= free_n;

  // R7
  take_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take0 |-> free_cnt != '0);
  // R7
  pair_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take1 |-> free_cnt > CW'(1));
  // R5
  give_was_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    give |-> !free_q[give_idx]);
endmodule

// File: rtl/rlm_lineq.sv
module rlm_lineq #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_val,
  input  logic                       pop,
  output logic [W-1:0]               front,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign front = mem[rd_q];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wr_q] <= push_val;
        wr_q      <= bump(wr_q);
      end
      if (pop) rd_q <= bump(rd_q);
      count <= count + CW'(push) - CW'(pop);
    end

  // R4
  lineq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> count < CW'(DEPTH));
  // R8
  lineq_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/reqlist_mgr.sv
module reqlist_mgr #(
  parameter int LINES   = 8,
  parameter int POOL    = 16,
  parameter int DATA_W  = 16,
  parameter int LINES_W = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rsv_valid,
  input  logic [LINES_W-1:0] rsv_line,
  input  logic               fill_valid,
  input  logic [LINES_W-1:0] fill_line,
  input  logic               net_valid,
  output logic               net_ready,
  input  logic [LINES_W-1:0] net_line,
  input  logic [DATA_W-1:0]  net_data,
  output logic               byp_valid,
  output logic [LINES_W-1:0] byp_line,
  output logic [DATA_W-1:0]  byp_data,
  output logic               act_valid,
  output logic [LINES_W-1:0] act_line,
  input  logic               act_pop,
  output logic               hd_valid,
  output logic [DATA_W-1:0]  hd_data,
  input  logic               hd_pop,
  input  logic               rq_valid,
  input  logic [DATA_W-1:0]  rq_data
);
  localparam int PW = $clog2(POOL);
  localparam int FW = $clog2(POOL + 1);
  localparam int QW = $clog2(LINES + 1);

  logic [PW-1:0]     head_q [LINES], head_n [LINES];
  logic [PW-1:0]     tail_q [LINES], tail_n [LINES];
  logic [PW-1:0]     link_q [POOL],  link_n [POOL];
  logic [DATA_W-1:0] body_q [POOL];
  logic [LINES-1:0]  busy_q, busy_n, lock_q, lock_n, inq_q, inq_n;

  logic [PW-1:0] slot0, slot1, rq_slot, park_slot;
  logic [FW-1:0] free_cnt;
  logic [QW-1:0] q_count;

  // named events
  logic rq_fire, pop_fire, park_fire, wants_park, taken;
  logic q_push, q_pop, front_keep;

  assign act_valid  = q_count != '0;
  assign hd_valid   = act_valid && busy_q[act_line];
  assign hd_data    = body_q[head_q[act_line]];
  assign rq_fire    = rq_valid && act_valid;
  assign pop_fire   = hd_pop && hd_valid;
  assign net_ready  = rq_fire ? (free_cnt >= FW'(2)) : (free_cnt != '0);
  assign taken      = net_valid && net_ready;
  assign wants_park = lock_q[net_line] || busy_q[net_line] ||
                      (rq_fire && act_line == net_line);
  assign park_fire  = taken && wants_park;
  assign byp_valid  = taken && !wants_park;
  assign byp_line   = net_line;
  assign byp_data   = net_data;
  assign rq_slot    = slot0;
  assign park_slot  = rq_fire ? slot1 : slot0;

  // list surgery: head removal, then head insertion, then tail append
  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    link_n = link_q;
    busy_n = busy_q;
    if (pop_fire) begin
      if (head_q[act_line] == tail_q[act_line]) busy_n[act_line] = 1'b0;
      else head_n[act_line] = link_q[head_q[act_line]];
    end
    if (rq_fire) begin
      if (busy_n[act_line]) link_n[rq_slot] = head_n[act_line];
      else                  tail_n[act_line] = rq_slot;
      head_n[act_line] = rq_slot;
      busy_n[act_line] = 1'b1;
    end
    if (park_fire) begin
      if (busy_n[net_line]) link_n[tail_n[net_line]] = park_slot;
      else                  head_n[net_line] = park_slot;
      tail_n[net_line] = park_slot;
      busy_n[net_line] = 1'b1;
    end
  end

  // lock state: a fresh lock overrides a fill on the same line
  always_comb begin
    lock_n = lock_q;
    if (fill_valid) lock_n[fill_line] = 1'b0;
    if (rsv_valid)  lock_n[rsv_line]  = 1'b1;
  end

  assign front_keep = busy_n[act_line] && !lock_n[act_line];
  assign q_pop      = act_pop && act_valid && !front_keep;

  always_comb begin
    inq_n = inq_q;
    if (q_pop) inq_n[act_line] = 1'b0;
    q_push = fill_valid && !lock_n[fill_line] && busy_n[fill_line] && !inq_n[fill_line];
    if (q_push) inq_n[fill_line] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= '0;
      lock_q <= '0;
      inq_q  <= '0;
      for (int l = 0; l < LINES; l++) begin
        head_q[l] <= '0;
        tail_q[l] <= '0;
      end
      for (int e = 0; e < POOL; e++) link_q[e] <= '0;
    end else begin
      busy_q <= busy_n;
      lock_q <= lock_n;
      inq_q  <= inq_n;
      head_q <= head_n;
      tail_q <= tail_n;
      link_q <= link_n;
    end

  always_ff @(posedge clk) begin
    if (rq_fire)   body_q[rq_slot]   <= rq_data;
    if (park_fire) body_q[park_slot] <= net_data;
  end

  rlm_freemap #(.DEPTH(POOL)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .take0    (rq_fire || park_fire),
    .take1    (rq_fire && park_fire),
    .give     (pop_fire),
    .give_idx (head_q[act_line]),
    .slot0    (slot0),
    .slot1    (slot1),
    .free_cnt (free_cnt)
  );

  rlm_lineq #(.DEPTH(LINES), .W(LINES_W)) u_lineq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (q_push),
    .push_val (fill_line),
    .pop      (q_pop),
    .front    (act_line),
    .count    (q_count)
  );

  // R6
  requeue_at_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_fire && !act_pop |=> hd_valid && hd_data == $past(rq_data));
  // R5
  pop_returns_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire && !rq_fire && !park_fire |=> free_cnt != '0);
  // R4
  fill_makes_servable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> act_valid);
endmodule

// File: tb/tb_reqlist_mgr.sv
module tb_reqlist_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int NP = 16;

  typedef logic [15:0] dq_t [$];

  logic        clk = 0, rst_n = 0;
  logic        rsv_valid = 0, fill_valid = 0, net_valid = 0, act_pop = 0, hd_pop = 0, rq_valid = 0;
  logic [2:0]  rsv_line = 0, fill_line = 0, net_line = 0;
  logic [15:0] net_data = 0, rq_data = 0;
  logic        net_ready, byp_valid, act_valid, hd_valid;
  logic [2:0]  byp_line, act_line;
  logic [15:0] byp_data, hd_data;

  int total = 0, bad = 0;
  dq_t mq [NL];
  bit [NL-1:0] m_lock = '0, m_inq = '0;
  int aq [$];
  bit [18:0] byp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  reqlist_mgr #(.LINES(NL), .POOL(NP), .DATA_W(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .rsv_valid(rsv_valid), .rsv_line(rsv_line),
    .fill_valid(fill_valid), .fill_line(fill_line),
    .net_valid(net_valid), .net_ready(net_ready), .net_line(net_line), .net_data(net_data),
    .byp_valid(byp_valid), .byp_line(byp_line), .byp_data(byp_data),
    .act_valid(act_valid), .act_line(act_line), .act_pop(act_pop),
    .hd_valid(hd_valid), .hd_data(hd_data), .hd_pop(hd_pop),
    .rq_valid(rq_valid), .rq_data(rq_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected values from the requirement model
  task automatic step(input string tag, input bit ra, input int rl, input bit fa, input int fl,
                      input bit nv, input int nl, input logic [15:0] nd,
                      input bit ap, input bit hp, input bit rv, input logic [15:0] rd);
    int front, used, spare;
    bit av, rqf, rdy, hv, pk, bp;
    @(negedge clk);
    rsv_valid = ra;  rsv_line = 3'(rl);
    fill_valid = fa; fill_line = 3'(fl);
    net_valid = nv;  net_line = 3'(nl); net_data = nd;
    act_pop = ap; hd_pop = hp; rq_valid = rv; rq_data = rd;
    #1;
    av = aq.size() > 0;
    front = av ? aq[0] : 0;
    used = 0;
    for (int l = 0; l < NL; l++) used += mq[l].size();
    spare = NP - used;
    rqf = rv && av;
    rdy = rqf ? (spare >= 2) : (spare >= 1);
    hv = av && mq[front].size() > 0;
    pk = nv && rdy && (m_lock[nl] || mq[nl].size() > 0 || (rqf && front == nl));
    bp = nv && rdy && !pk;
    chk(net_ready === rdy, {tag, " R7 ready"}, int'(net_ready), int'(rdy));
    chk(byp_valid === bp, {tag, " R2 bypass"}, int'(byp_valid), int'(bp));
    chk(act_valid === av, {tag, " R10 act_valid"}, int'(act_valid), int'(av));
    if (av) chk(act_line === 3'(front), {tag, " R10 act_line"}, int'(act_line), front);
    chk(hd_valid === hv, {tag, " R5 hd_valid"}, int'(hd_valid), int'(hv));
    if (hv) chk(hd_data === mq[front][0], {tag, " R5 hd_data"}, int'(hd_data), int'(mq[front][0]));
    if (bp) byp_q.push_back({3'(nl), nd});
    if (hp && hv) void'(mq[front].pop_front());
    if (rqf) mq[front].push_front(rd);
    if (pk) mq[nl].push_back(nd);
    if (fa) m_lock[fl] = 1'b0;
    if (ra) m_lock[rl] = 1'b1;
    if (ap && av && !(mq[front].size() > 0 && !m_lock[front])) begin
      m_inq[front] = 1'b0;
      void'(aq.pop_front());
    end
    if (fa && !m_lock[fl] && mq[fl].size() > 0 && !m_inq[fl]) begin
      aq.push_back(fl);
      m_inq[fl] = 1'b1;
    end
    @(posedge clk);
    #1;
    rsv_valid = 0; fill_valid = 0; net_valid = 0; act_pop = 0; hd_pop = 0; rq_valid = 0;
  endtask

  task automatic reserve(input string t, input int l); step(t, 1, l, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic fill(input string t, input int l);    step(t, 0, 0, 1, l, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic arrive(input string t, input int l, input logic [15:0] d); step(t, 0, 0, 0, 0, 1, l, d, 0, 0, 0, 0); endtask
  task automatic pop(input string t);                 step(t, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0); endtask
  task automatic requeue(input string t, input logic [15:0] d); step(t, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, d); endtask
  task automatic retire(input string t);              step(t, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); endtask
  task automatic idle(input string t);                step(t, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  // monitor: pops the expected bypass items as they appear
  always @(posedge clk) begin
    if (rst_n && byp_valid) begin
      if (byp_q.size() == 0) chk(1'b0, "R2 unexpected bypass", int'(byp_data), 0);
      else begin
        bit [18:0] e;
        e = byp_q.pop_front();
        chk({byp_line, byp_data} === e, "R2 bypass item", int'({byp_line, byp_data}), int'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(net_ready === 1'b1, "R1 ready", int'(net_ready), 1);
    chk(act_valid === 1'b0, "R1 act_valid", int'(act_valid), 0);
    chk(hd_valid === 1'b0, "R1 hd_valid", int'(hd_valid), 0);
    chk(byp_valid === 1'b0, "R1 byp_valid", int'(byp_valid), 0);

    arrive("R2 free line", 2, 16'h1111);
    // R3: locked line parks in arrival order
    reserve("R3", 3);
    arrive("R3", 3, 16'hA001);
    arrive("R3", 3, 16'hA002);
    arrive("R3", 3, 16'hA003);
    // R4: fill on an empty locked line queues nothing
    reserve("R4", 4);
    fill("R4 empty", 4);
    idle("R4 empty");
    fill("R4", 3);
    // R3: unlocked but non-empty line still parks at the tail
    arrive("R3 tail", 3, 16'hA004);
    pop("R5");
    pop("R5");
    // R6: re-inserted request comes back first
    requeue("R6", 16'hA002);
    idle("R6");
    pop("R6");
    // R8: retire ignored while line unlocked and non-empty
    retire("R8 keep");
    pop("R5");
    pop("R5");
    retire("R8 drop");
    idle("R8 empty");
    arrive("R2 after drain", 3, 16'h2222);

    // R10 order of servable lines, R4 queued once
    reserve("R10", 5);
    reserve("R10", 6);
    arrive("R10", 6, 16'hB006);
    arrive("R10", 5, 16'hB005);
    fill("R10", 6);
    fill("R10", 5);
    reserve("R4 relock", 6);
    fill("R4 once", 6);
    pop("R10");
    retire("R10");
    pop("R10");
    retire("R10");
    idle("R4 once");

    // R9: lock and fill on the same line in one cycle, lock wins
    reserve("R9", 7);
    arrive("R9", 7, 16'hC007);
    step("R9", 1, 7, 1, 7, 0, 0, 0, 0, 0, 0, 0);
    arrive("R9 still locked", 7, 16'hC008);
    fill("R9", 7);
    pop("R9");
    pop("R9");
    retire("R9");

    // R7: exhaust the pool
    reserve("R7", 0);
    for (int i = 0; i < NP; i++) arrive("R7 fill pool", 0, 16'(16'hD000 + i));
    arrive("R7 full", 0, 16'hDEAD);
    arrive("R7 full other line", 1, 16'hBEEF);
    fill("R7", 0);
    pop("R5 free one");
    step("R7 last slot to requeue", 0, 0, 0, 0, 1, 0, 16'hDEAF, 0, 0, 1, 16'hD000);
    pop("R5 reuse");
    arrive("R7 slot back", 0, 16'hD100);
    for (int i = 0; i < NP + 1; i++) pop("R5 drain");
    retire("R8");
    idle("R1 quiet");

    #1;
    chk(byp_q.size() == 0, "R2 bypass queue empty", byp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule